// File: doc/BRIEF.md
# Configurable Crosspoint Switch Matrix

A bit-wide crosspoint switch joining `NPORTS` one-bit pad cells. Every port has its own configuration word. The word sets the port's direction mode (input, output, bidirectional or repeater), the port it takes its data from, and whether its output is registered or flow-through. It also sets output inversion, which of two input enables and which of two output enables the port obeys, and which strobe clocks its output register. Any input-capable port can feed any number of outputs. Each output listens to exactly one source.

Software writes configuration words into a shadow bank. These writes change nothing at the pads. A one-cycle update strobe then copies the whole shadow bank into the active bank, so every route and mode changes on the same clock edge. Either bank can be read back at any address. The pad is modelled as three separate signals: `pad_in`, `pad_out` and `pad_oe`.

Registered ports sample on the core clock `clk`, but only in cycles when their selected strobe is high. The strobe is one of two global strobes or the raw pad input of the next port up, wrapping from the last port to port 0.

Top module: `xp_switch`

## Requirements
- R1: While `rst` is high, and after it falls, both banks hold all-zero words. Every port is then in input mode with source 0, so `pad_oe` and `pad_out` are all zero and readback gives zero.
- R2: A write (`cfg_we` high at a rising edge) stores `cfg_wdata` into the shadow word at `cfg_addr` and does not change the active bank or the pads. The word layout is: bits [S-1:0] source port, where S = clog2(NPORTS); [S+1:S] mode (0 input, 1 output, 2 bidirectional, 3 repeater); S+2 registered; S+3 invert; S+4 input-enable select; S+5 output-enable select; [S+7:S+6] strobe select.
- R3: At a rising edge with `cfg_upd` high, the active bank becomes the shadow bank as it stood before that edge, for all ports at once. A write in the same cycle reaches the shadow bank only. Without `cfg_upd`, the active bank holds.
- R4: Every output-capable port carries the value of its selected source, and any number of ports may select the same source.
- R5: Input mode gives `pad_oe`=0 and `pad_out`=0. Output and bidirectional modes give `pad_oe` = `out_en[oen_select]`. Repeater mode gives `pad_oe`=1.
- R6: A source port contributes its `pad_in` only when it is in input or bidirectional mode and `in_en[ien_select]` is high. Otherwise it contributes 0.
- R7: In flow-through mode the port outputs the source value XOR its invert bit, combinationally, in the same cycle as the input.
- R8: Each port register loads the source value at a rising edge of `clk` when its strobe is high (select 0: `gstrb[0]`, 1: `gstrb[1]`, 2: `pad_in` of port (i+1) mod NPORTS, 3: never), and holds otherwise. In registered mode the port outputs this register, and the invert bit has no effect.
- R9: A port that selects itself as source receives 0, so a bidirectional port never loops its own pad back into its output.
- R10: `cfg_rdata` is, combinationally, the shadow word at `cfg_addr` when `cfg_rd_active` is 0, and the active word when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Shadow write strobe |
| cfg_addr | input | clog2(NPORTS) | Port address for writes and readback |
| cfg_wdata | input | clog2(NPORTS)+8 | Configuration word to write |
| cfg_upd | input | 1 | Copy shadow bank into active bank |
| cfg_rd_active | input | 1 | Readback bank select (1 = active) |
| cfg_rdata | output | clog2(NPORTS)+8 | Readback word |
| in_en | input | 2 | Global input enables |
| out_en | input | 2 | Global output enables |
| gstrb | input | 2 | Global register strobes |
| pad_in | input | NPORTS | Pad input values |
| pad_out | output | NPORTS | Pad output values |
| pad_oe | output | NPORTS | Pad drive enables |

## Verification
The bench targets four timing faults:
- A write and an update in the same cycle. A design that forwards the new word into the active bank would move a route one update too early.
- Pads seen between a write and its update. A design that writes through to the active bank would change a pad there.
- A self-routed bidirectional port. A design that did not force 0 here would echo `pad_in`.
- A registered port whose strobe is low while its inverted source toggles. A design that updated the register on every edge, or applied inversion to it, would show the toggles.

The bench also sweeps readback of both banks, gates sources with the input enables, and drives neighbour-pad strobes. A long random phase then mixes writes, updates and pad traffic.

// File: rtl/xp_pkg.sv
package xp_pkg;

  typedef enum logic [1:0] {
    PM_IN    = 2'd0,
    PM_OUT   = 2'd1,
    PM_BIDIR = 2'd2,
    PM_RPT   = 2'd3
  } pmode_t;

  // Control part of a port word; the source index sits below it.
  typedef struct packed {
    logic [1:0] clk_sel;
    logic       oen_sel;
    logic       ien_sel;
    logic       inv;
    logic       regd;
    pmode_t     mode;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic takes_input(pmode_t m);
    return (m == PM_IN) || (m == PM_BIDIR);
  endfunction

  function automatic logic drives_pad(pmode_t m);
    return m != PM_IN;
  endfunction

endpackage

// File: rtl/xp_cfg_bank.sv
module xp_cfg_bank #(
  parameter int NPORTS = 8,
  parameter int WORD_W = 11,
  localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SEL_W-1:0]         waddr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic                     upd,
  output logic [NPORTS*WORD_W-1:0] shadow_flat,
  output logic [NPORTS*WORD_W-1:0] active_flat
);

  logic [WORD_W-1:0] shadow_q [NPORTS];
  logic [WORD_W-1:0] active_q [NPORTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPORTS; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
    end else begin
      if (upd) active_q <= shadow_q;
      if (we && int'(waddr) < NPORTS) shadow_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_flat
    assign shadow_flat[g*WORD_W +: WORD_W] = shadow_q[g];
    assign active_flat[g*WORD_W +: WORD_W] = active_q[g];
  end

endmodule

// File: rtl/xp_port_cell.sv
module xp_port_cell
  import xp_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int IDX    = 0,
  localparam int SEL_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int WORD_W = SEL_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cfg,
  input  logic [NPORTS-1:0] src_vec,
  input  logic [1:0]        oen,
  input  logic [1:0]        strb,
  input  logic              nbr,
  output logic              pad_out,
  output logic              pad_oe
);

  ctl_t             ctl;
  logic [SEL_W-1:0] src;
  logic             raw;
  logic             tick;
  logic             q;
  logic             data;

  assign ctl = ctl_t'(cfg[WORD_W-1:SEL_W]);
  assign src = cfg[SEL_W-1:0];

  // Self-selection yields 0 so a bidirectional pad cannot feed itself.
  always_comb begin
    raw = 1'b0;
    if (int'(src) != IDX && int'(src) < NPORTS) raw = src_vec[src];
  end

  always_comb begin
    case (ctl.clk_sel)
      2'd0:    tick = strb[0];
      2'd1:    tick = strb[1];
      2'd2:    tick = nbr;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (tick) q <= raw;
  end

  assign data = ctl.regd ? q : (raw ^ ctl.inv);

  always_comb begin
    case (ctl.mode)
      PM_IN:   pad_oe = 1'b0;
      PM_RPT:  pad_oe = 1'b1;
      default: pad_oe = oen[ctl.oen_sel];
    endcase
  end

  assign pad_out = drives_pad(ctl.mode) ? data : 1'b0;

endmodule

// File: rtl/xp_switch.sv
module xp_switch
  import xp_pkg::*;
#(
  parameter int NPORTS = 8,
  localparam int SEL_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int WORD_W = SEL_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_upd,
  input  logic              cfg_rd_active,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [1:0]        in_en,
  input  logic [1:0]        out_en,
  input  logic [1:0]        gstrb,
  input  logic [NPORTS-1:0] pad_in,
  output logic [NPORTS-1:0] pad_out,
  output logic [NPORTS-1:0] pad_oe
);

  logic [NPORTS*WORD_W-1:0] shadow_flat;
  logic [NPORTS*WORD_W-1:0] active_flat;
  logic [NPORTS-1:0]        src_vec;

  xp_cfg_bank #(.NPORTS(NPORTS), .WORD_W(WORD_W)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .we          (cfg_we),
    .waddr       (cfg_addr),
    .wdata       (cfg_wdata),
    .upd         (cfg_upd),
    .shadow_flat (shadow_flat),
    .active_flat (active_flat)
  );

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_addr) < NPORTS)
      cfg_rdata = cfg_rd_active ? active_flat[int'(cfg_addr)*WORD_W +: WORD_W]
                                : shadow_flat[int'(cfg_addr)*WORD_W +: WORD_W];
  end

  for (genvar j = 0; j < NPORTS; j++) begin : g_port
    ctl_t ctl_j;
    assign ctl_j = ctl_t'(active_flat[j*WORD_W+SEL_W +: CTL_W]);
    assign src_vec[j] = takes_input(ctl_j.mode) && in_en[ctl_j.ien_sel] && pad_in[j];

    xp_port_cell #(.NPORTS(NPORTS), .IDX(j)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .cfg     (active_flat[j*WORD_W +: WORD_W]),
      .src_vec (src_vec),
      .oen     (out_en),
      .strb    (gstrb),
      .nbr     (pad_in[(j+1) % NPORTS]),
      .pad_out (pad_out[j]),
      .pad_oe  (pad_oe[j])
    );
  end

endmodule

// File: rtl/xp_switch_chk.sv
module xp_switch_chk
  import xp_pkg::*;
#(
  parameter int NPORTS = 8,
  localparam int SEL_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int WORD_W = SEL_W + CTL_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_we,
  input logic                     cfg_upd,
  input logic [NPORTS*WORD_W-1:0] shadow_flat,
  input logic [NPORTS*WORD_W-1:0] active_flat,
  input logic [NPORTS-1:0]        pad_out,
  input logic [NPORTS-1:0]        pad_oe
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (shadow_flat == '0 && active_flat == '0));

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(shadow_flat));

  // R3
  update_copy_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_upd |=> (active_flat == $past(shadow_flat)));

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_upd |=> $stable(active_flat));

  for (genvar i = 0; i < NPORTS; i++) begin : g_pad
    pmode_t m;
    assign m = pmode_t'(active_flat[i*WORD_W+SEL_W +: 2]);

    // R5
    input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (m == PM_IN) |-> (!pad_oe[i] && !pad_out[i]));

    // R5
    repeater_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (m == PM_RPT) |-> pad_oe[i]);
  end

endmodule

bind xp_switch xp_switch_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_upd     (cfg_upd),
  .shadow_flat (shadow_flat),
  .active_flat (active_flat),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe)
);

// File: tb/xp_switch_bench.sv
module xp_switch_bench;

  localparam int N  = 8;
  localparam int SW = 3;
  localparam int W  = SW + 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_addr = '0;
  logic [W-1:0]  cfg_wdata = '0;
  logic          cfg_upd = 1'b0;
  logic          cfg_rd_active = 1'b0;
  logic [W-1:0]  cfg_rdata;
  logic [1:0]    in_en = 2'b00;
  logic [1:0]    out_en = 2'b00;
  logic [1:0]    gstrb = 2'b00;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;

  xp_switch #(.NPORTS(N)) u_xp_switch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_upd(cfg_upd), .cfg_rd_active(cfg_rd_active),
    .cfg_rdata(cfg_rdata), .in_en(in_en), .out_en(out_en), .gstrb(gstrb),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int    sh [N];
  int    ac [N];
  int    q  [N];
  int    errors = 0;
  int    checks = 0;
  string phase  = "R1";
  bit    done   = 0;

  function automatic int fld(int w, int lo, int n);
    return (w >> lo) & ((1 << n) - 1);
  endfunction

  // Word builder per R2 layout.
  function automatic int mk(int src, int mode, int regd, int inv,
                            int ies, int oes, int cks);
    return src | (mode << 3) | (regd << 5) | (inv << 6) |
           (ies << 7) | (oes << 8) | (cks << 9);
  endfunction

  function automatic bit m_src(int j);
    int m;
    m = fld(ac[j], 3, 2);
    return (m == 0 || m == 2) && in_en[fld(ac[j], 7, 1)] && pad_in[j];
  endfunction

  function automatic bit m_raw(int i);
    int s;
    s = fld(ac[i], 0, 3);
    if (s == i) return 1'b0;
    return m_src(s);
  endfunction

  function automatic bit m_tick(int i);
    int c;
    c = fld(ac[i], 9, 2);
    if (c == 0) return gstrb[0];
    if (c == 1) return gstrb[1];
    if (c == 2) return pad_in[(i + 1) % N];
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] m_out();
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) begin
      bit d;
      d = fld(ac[i], 5, 1) != 0 ? q[i][0] : (m_raw(i) ^ fld(ac[i], 6, 1)[0]);
      if (fld(ac[i], 3, 2) != 0) v[i] = d;
    end
    return v;
  endfunction

  function automatic logic [N-1:0] m_oe();
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) begin
      int m;
      m = fld(ac[i], 3, 2);
      if (m == 3) v[i] = 1'b1;
      else if (m != 0) v[i] = out_en[fld(ac[i], 8, 1)];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin sh[i] = 0; ac[i] = 0; q[i] = 0; end
    end else begin
      int nq [N];
      int na [N];
      for (int i = 0; i < N; i++) nq[i] = m_tick(i) ? int'(m_raw(i)) : q[i];
      for (int i = 0; i < N; i++) na[i] = cfg_upd ? sh[i] : ac[i];
      if (cfg_we) sh[cfg_addr] = int'(cfg_wdata);
      for (int i = 0; i < N; i++) begin q[i] = nq[i]; ac[i] = na[i]; end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("pad_out", 32'(pad_out), 32'(m_out()));
      chk("pad_oe", 32'(pad_oe), 32'(m_oe()));
      chk("cfg_rdata", 32'(cfg_rdata),
          32'(cfg_rd_active ? ac[cfg_addr] : sh[cfg_addr]));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, int v);
    cfg_we = 1'b1; cfg_addr = SW'(a); cfg_wdata = W'(v);
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic upd();
    cfg_upd = 1'b1;
    cyc();
    cfg_upd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    @(negedge clk);
    chk("R1 oe after reset", 32'(pad_oe), 32'h0);
    cyc();

    phase = "R10";
    for (int a = 0; a < N; a++) begin
      cfg_addr = SW'(a); cfg_rd_active = a[0]; cyc();
    end

    phase = "R2";
    in_en = 2'b11; out_en = 2'b11; pad_in = 8'h01;
    wr(1, mk(0, 1, 0, 0, 0, 0, 0));
    cfg_addr = 3'd1; cfg_rd_active = 1'b0;
    @(negedge clk);
    chk("R2 shadow readback", 32'(cfg_rdata), 32'(mk(0, 1, 0, 0, 0, 0, 0)));
    chk("R2 pad not yet driven", 32'(pad_oe[1]), 32'h0);
    cyc();

    phase = "R3";
    wr(2, mk(0, 1, 0, 0, 0, 0, 0));
    wr(3, mk(0, 1, 0, 0, 0, 0, 0));
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = W'(mk(0, 3, 0, 0, 0, 0, 0));
    upd();
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R3 routes together", 32'(pad_out[3:1]), 32'h7);
    chk("R3 same-cycle write not active", 32'(pad_oe[4]), 32'h0);
    cyc();
    upd();

    phase = "R4";
    for (int k = 0; k < 12; k++) begin pad_in = N'(k * 37); cyc(); end

    phase = "R5";
    wr(1, mk(0, 1, 0, 0, 0, 1, 0));
    wr(2, mk(0, 2, 0, 0, 0, 0, 0));
    upd();
    for (int k = 0; k < 4; k++) begin out_en = 2'(k); cyc(); end
    out_en = 2'b11;

    phase = "R6";
    wr(5, mk(0, 0, 0, 0, 1, 0, 0));
    wr(6, mk(5, 1, 0, 0, 0, 0, 0));
    upd();
    pad_in = 8'h21;
    for (int k = 0; k < 4; k++) begin in_en = 2'(k); cyc(); end
    in_en = 2'b11;
    wr(5, mk(0, 1, 0, 0, 0, 0, 0));
    upd();
    @(negedge clk);
    chk("R6 output-mode source gives 0", 32'(pad_out[6]), 32'h0);
    cyc();

    phase = "R7";
    wr(3, mk(0, 1, 0, 1, 0, 0, 0));
    upd();
    pad_in = 8'h00;
    @(negedge clk);
    chk("R7 inverted flow-through", 32'(pad_out[3]), 32'h1);
    cyc();

    phase = "R8";
    gstrb = 2'b00;
    wr(4, mk(0, 1, 1, 1, 0, 0, 1));
    upd();
    for (int k = 0; k < 6; k++) begin pad_in[0] = ~pad_in[0]; cyc(); end
    pad_in[0] = 1'b1; gstrb = 2'b10; cyc();
    gstrb = 2'b00; pad_in[0] = 1'b0;
    @(negedge clk);
    chk("R8 register holds captured 1, no inversion", 32'(pad_out[4]), 32'h1);
    cyc();
    wr(7, mk(0, 1, 1, 0, 0, 0, 2));
    upd();
    for (int k = 0; k < 8; k++) begin pad_in = N'(k * 3); cyc(); end

    phase = "R9";
    wr(2, mk(2, 2, 0, 0, 0, 0, 0));
    upd();
    pad_in = 8'h04;
    @(negedge clk);
    chk("R9 self route blocked", 32'(pad_out[2]), 32'h0);
    cyc();

    phase = "R4 R6 R8 R10 mixed";
    for (int k = 0; k < 3000; k++) begin
      pad_in = N'($urandom); in_en = 2'($urandom); out_en = 2'($urandom);
      gstrb = 2'($urandom); cfg_rd_active = 1'($urandom);
      cfg_addr = SW'($urandom);
      cfg_we = ($urandom % 6) == 0;
      cfg_wdata = W'($urandom);
      cfg_upd = ($urandom % 12) == 0;
      cyc();
    end
    cfg_we = 1'b0; cfg_upd = 1'b0;
    cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule